// File: doc/BRIEF.md
# Bidirectional Port with Peripheral Pin Takeover

This block is one 8-bit general-purpose I/O port that hangs off a small processor's register bus. Each pin owns a data latch bit and a direction bit. A processor write to the data address loads the latches, and a write to the direction address chooses which pins drive. Reads at the data address return a mix. A pin set as an output returns its latch bit. A pin set as an input returns its pad level after a two-flop synchronizer. The pad side of the block is three vectors: output enable, output value and input value. The outputs come straight from flip-flops.

Two pins can be handed to on-chip peripherals through an option register. When the output takeover bit is set, one pin is driven by a peripheral output and its latch and direction bits are ignored. When the input takeover bit is set, another pin stops driving and its synchronized level goes to an internal consumer. The input-capable pin is open-drain: it can only pull low or release the line.

Reset clears the direction and option registers, so every pin becomes an undriven plain port pin. The data latches are not touched by reset, so software can preload them before it turns on any outputs.

Top module: `gpio_altport`

## Requirements
- R1: A bus write to address 0x03 loads the data latch. A read of 0x03 returns the latch bit for every pin whose direction bit is 1. `bus_rdata` is registered: it holds the result on the clock edge that follows the edge where the address is sampled.
- R2: A bus write to address 0x07 loads the direction register, and a read of 0x07 returns it. On a plain pin, direction bit 1 drives the pad: `pad_oe` follows the direction bit and `pad_out` follows the latch bit, one clock edge after the register edge.
- R3: A synchronous reset (`rst` high) clears the direction and option registers. It drives `pad_oe` and `pad_out` to all zeros, `bus_rdata` to zero and `alt_in_o` to 1.
- R4: Reset leaves the data latch unchanged.
- R5: For a pin whose direction bit is 0, a read of 0x03 returns the pad level through a two-flop synchronizer. After a pad change, the third rising edge is the first edge at which `bus_rdata` shows the new level.
- R6: The option register sits at address 0x0B. Bit 0 enables the output takeover and bit 1 enables the input takeover. Reads return those two bits and zero in bits 7..2.
- R7: With option bit 0 set, pin 2 always drives (`pad_oe[2]`=1), and `pad_out[2]` is `alt_out_i` registered one edge. Latch bit 2 and direction bit 2 have no effect on pin 2.
- R8: With option bit 1 set, pin 3 never drives, and `alt_in_o` carries the synchronized level of `pad_in[3]` (three edges after a pad change). With bit 1 clear, `alt_in_o` stays at 1.
- R9: Pin 3 is open-drain. `pad_out[3]` is always 0. As a plain output, it drives (`pad_oe[3]`=1) only when latch bit 3 is 0.
- R10: Reads of any address other than 0x03, 0x07 and 0x0B return zero. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous edge |
| alt_out_i | input | 1 | Peripheral output value to be driven on pin 2 |
| alt_in_o | output | 1 | Synchronized pin 3 level for the internal consumer; 1 when not taken over |
| pad_in | input | 8 | Levels seen at the pads |
| pad_oe | output | 8 | Pad drive enables |
| pad_out | output | 8 | Pad drive values |

## Verification
The assertions check the following properties on every cycle:
- The open-drain pin never drives high.
- The output-takeover pin always drives the registered peripheral value.
- The input-takeover pin is released, and `alt_in_o` idles high when the takeover is off.
- Reset clears direction and option.
- Writes to unmapped addresses leave every register unchanged, and reads from them return zero.

Some behaviours can only be shown by the bench's scenarios:
- The data latch survives a reset.
- The synchronizer latency is exactly three edges.
- The per-pin read mix of latch and pad levels is correct.
- The full pad vectors match a model under random direction, latch, option and pad patterns.

// File: rtl/gpio_altport_pkg.sv
package gpio_altport_pkg;
  localparam int OPT_W       = 2;
  localparam int OPT_OUT_BIT = 0;
  localparam int OPT_IN_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_OPT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_altport_pkg::*;
#(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h03,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h07,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [OPT_W-1:0]  opt_q,
  output logic [WIDTH-1:0]  bus_rdata
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] rd_next;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == DATA_ADDR)     sel = SEL_DATA;
    else if (bus_addr == DIR_ADDR) sel = SEL_DIR;
    else if (bus_addr == OPT_ADDR) sel = SEL_OPT;
  end

  // Data latch: deliberately outside reset (R4)
  always_ff @(posedge clk) begin
    if (bus_wr && sel == SEL_DATA) data_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      opt_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_DIR) dir_q <= bus_wdata;
      if (sel == SEL_OPT) opt_q <= bus_wdata[OPT_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DATA: rd_next = (dir_q & data_q) | (~dir_q & pin_sync);
      SEL_DIR:  rd_next = dir_q;
      SEL_OPT:  rd_next[OPT_W-1:0] = opt_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  p_dir_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == '0 && opt_q == '0));

  p_unmapped_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr) && $past(sel) == SEL_NONE)
      |-> (dir_q == $past(dir_q) && opt_q == $past(opt_q) && data_q == $past(data_q)));

  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == SEL_NONE) |-> bus_rdata == '0);

  p_dir_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == SEL_DIR) |-> bus_rdata == $past(dir_q));
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= pad_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign pin_sync = stg[STAGES-1];

  p_sync_chain_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stg[0] == $past(pad_in));
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux
  import gpio_altport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ALT_OUT_PIN = 2,
  parameter int ALT_IN_PIN  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [OPT_W-1:0] opt_q,
  input  logic             alt_out_i,
  input  logic             alt_in_raw,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic             alt_in_o
);
  logic [WIDTH-1:0] oe_n;
  logic [WIDTH-1:0] out_n;
  logic             take_out;
  logic             take_in;

  assign take_out = opt_q[OPT_OUT_BIT];
  assign take_in  = opt_q[OPT_IN_BIT];

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    if (g == ALT_OUT_PIN) begin : g_alt_out
      assign oe_n[g]  = take_out | dir_q[g];
      assign out_n[g] = take_out ? alt_out_i : data_q[g];
    end else if (g == ALT_IN_PIN) begin : g_open_drain
      assign oe_n[g]  = !take_in && dir_q[g] && !data_q[g];
      assign out_n[g] = 1'b0;
    end else begin : g_plain
      assign oe_n[g]  = dir_q[g];
      assign out_n[g] = data_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe   <= '0;
      pad_out  <= '0;
      alt_in_o <= 1'b1;
    end else begin
      pad_oe   <= oe_n;
      pad_out  <= out_n;
      alt_in_o <= take_in ? alt_in_raw : 1'b1;
    end
  end

  p_altout_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take_out))
      |-> (pad_oe[ALT_OUT_PIN] && pad_out[ALT_OUT_PIN] == $past(alt_out_i)));

  p_od_low_only_r9: assert property (@(posedge clk) disable iff (rst)
    pad_oe[ALT_IN_PIN] |-> !pad_out[ALT_IN_PIN]);

  p_altin_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take_in)) |-> !pad_oe[ALT_IN_PIN]);

  p_altin_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(take_in)) |-> alt_in_o);
endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
  import gpio_altport_pkg::*;
#(
  parameter int                WIDTH       = 8,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                ALT_OUT_PIN = 2,
  parameter int                ALT_IN_PIN  = 3,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 'h03,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 'h07,
  parameter logic [ADDR_W-1:0] OPT_ADDR    = 'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              alt_out_i,
  output logic              alt_in_o,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out
);
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [OPT_W-1:0] opt_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_insync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pin_sync(pin_sync)
  );

  gpio_regbank #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W),
    .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .OPT_ADDR(OPT_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_sync(pin_sync), .data_q(data_q),
    .dir_q(dir_q), .opt_q(opt_q), .bus_rdata(bus_rdata)
  );

  gpio_padmux #(
    .WIDTH(WIDTH), .ALT_OUT_PIN(ALT_OUT_PIN), .ALT_IN_PIN(ALT_IN_PIN)
  ) u_mux (
    .clk(clk), .rst(rst), .data_q(data_q), .dir_q(dir_q), .opt_q(opt_q),
    .alt_out_i(alt_out_i), .alt_in_raw(pin_sync[ALT_IN_PIN]),
    .pad_oe(pad_oe), .pad_out(pad_out), .alt_in_o(alt_in_o)
  );
endmodule

// File: tb/gpio_altport_tb.sv
module gpio_altport_tb;
  localparam logic [7:0] A_DATA = 8'h03;
  localparam logic [7:0] A_DIR  = 8'h07;
  localparam logic [7:0] A_OPT  = 8'h0B;
  localparam int PO = 2;
  localparam int PI = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       alt_out_i = 1'b0;
  logic       alt_in_o;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_altport u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_out_i(alt_out_i),
    .alt_in_o(alt_in_o), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  function automatic logic [7:0] m_oe(logic [7:0] dir, logic [7:0] dat, logic [1:0] opt);
    logic [7:0] r = dir;
    r[PO] = opt[0] | dir[PO];
    r[PI] = !opt[1] && dir[PI] && !dat[PI];
    return r;
  endfunction

  function automatic logic [7:0] m_out(logic [7:0] dat, logic [1:0] opt, logic alt);
    logic [7:0] r = dat;
    r[PO] = opt[0] ? alt : dat[PO];
    r[PI] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] m_rd(logic [7:0] dir, logic [7:0] dat, logic [7:0] pad);
    return (dir & dat) | (~dir & pad);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h0005EED1));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3 reset state
    chk("R3 pad_oe after reset", pad_oe, 8'h00);
    chk("R3 pad_out after reset", pad_out, 8'h00);
    chk("R3 rdata after reset", bus_rdata, 8'h00);
    chk("R3 alt_in_o after reset", alt_in_o, 1'b1);
    rd(A_DIR, d); chk("R3 dir cleared", d, 8'h00);
    rd(A_OPT, d); chk("R3 opt cleared", d, 8'h00);

    // R1 / R2 basic output
    wr(A_DATA, 8'h5A);
    wr(A_DIR, 8'hFF);
    settle(1);
    chk("R2 pad_oe output", pad_oe, m_oe(8'hFF, 8'h5A, 2'b00));
    chk("R2 pad_out output", pad_out, m_out(8'h5A, 2'b00, 1'b0));
    rd(A_DATA, d); chk("R1 latch readback", d, 8'h5A);
    rd(A_DIR, d);  chk("R2 dir readback", d, 8'hFF);

    // R4 latch survives reset
    wr(A_DATA, 8'hC3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(A_DIR, d); chk("R3 dir cleared by mid reset", d, 8'h00);
    chk("R3 pad_oe cleared by mid reset", pad_oe, 8'h00);
    wr(A_DIR, 8'hFF);
    rd(A_DATA, d); chk("R4 latch kept over reset", d, 8'hC3);

    // R5 input read through synchronizer
    wr(A_DIR, 8'h00);
    pad_in = 8'h96;
    settle(3);
    rd(A_DATA, d); chk("R5 input read", d, 8'h96);
    wr(A_DIR, 8'h0F); wr(A_DATA, 8'hA5); pad_in = 8'h3C;
    settle(3);
    rd(A_DATA, d); chk("R5 mixed read", d, m_rd(8'h0F, 8'hA5, 8'h3C));
    // R5 latency: new level first visible after third edge
    wr(A_DIR, 8'h00); pad_in = 8'h00; settle(3);
    @(negedge clk); bus_addr = A_DATA; pad_in = 8'hFF;
    @(negedge clk); chk("R5 latency edge1", bus_rdata, 8'h00);
    @(negedge clk); chk("R5 latency edge2", bus_rdata, 8'h00);
    @(negedge clk); chk("R5 latency edge3", bus_rdata, 8'hFF);
    bus_addr = 8'h00;

    // R6 option register
    wr(A_OPT, 8'hFF);
    rd(A_OPT, d); chk("R6 opt readback masks upper bits", d, 8'h03);

    // R7 output takeover
    wr(A_OPT, 8'h01); wr(A_DIR, 8'h00); wr(A_DATA, 8'h00);
    alt_out_i = 1'b1; settle(1);
    chk("R7 takeover oe", pad_oe[PO], 1'b1);
    chk("R7 takeover value 1", pad_out[PO], 1'b1);
    @(negedge clk); alt_out_i = 1'b0;
    @(negedge clk); chk("R7 takeover value 0 next edge", pad_out[PO], 1'b0);
    wr(A_DATA, 8'hFF); wr(A_DIR, 8'hFF); settle(1);
    chk("R7 latch ignored", pad_out[PO], 1'b0);

    // R8 input takeover
    wr(A_OPT, 8'h02); wr(A_DATA, 8'h00); wr(A_DIR, 8'hFF);
    pad_in = 8'h00; settle(3);
    chk("R8 pin released", pad_oe[PI], 1'b0);
    chk("R8 alt_in low", alt_in_o, 1'b0);
    pad_in = 8'h08; settle(3);
    chk("R8 alt_in high", alt_in_o, 1'b1);
    pad_in = 8'h00; wr(A_OPT, 8'h00); settle(3);
    chk("R8 alt_in idle when off", alt_in_o, 1'b1);

    // R9 open drain
    wr(A_DIR, 8'h08); wr(A_DATA, 8'h00); settle(1);
    chk("R9 od drives low oe", pad_oe[PI], 1'b1);
    chk("R9 od drives low value", pad_out[PI], 1'b0);
    wr(A_DATA, 8'h08); settle(1);
    chk("R9 od released on 1", pad_oe[PI], 1'b0);

    // R10 unmapped
    wr(A_DIR, 8'h5C); wr(A_DATA, 8'h33); wr(A_OPT, 8'h01);
    wr(8'h05, 8'hFF); wr(8'h83, 8'h00); wr(8'h0A, 8'hFF);
    rd(A_DIR, d);  chk("R10 dir untouched", d, 8'h5C);
    rd(A_OPT, d);  chk("R10 opt untouched", d, 8'h01);
    wr(A_DIR, 8'hFF);
    rd(A_DATA, d); chk("R10 latch untouched", d, 8'h33);
    rd(8'h05, d);  chk("R10 unmapped read 05", d, 8'h00);
    rd(8'hFF, d);  chk("R10 unmapped read FF", d, 8'h00);

    // Random mix: R2 R5 R7 R8 R9
    for (int i = 0; i < 300; i++) begin
      logic [7:0] rdir, rdat, rpad;
      logic [1:0] ropt;
      logic       ralt;
      rdir = 8'($urandom()); rdat = 8'($urandom()); rpad = 8'($urandom());
      ropt = 2'($urandom()); ralt = 1'($urandom());
      wr(A_DATA, rdat); wr(A_DIR, rdir); wr(A_OPT, {6'b0, ropt});
      pad_in = rpad; alt_out_i = ralt;
      settle(3);
      chk("R2 R7 R9 random pad_oe", pad_oe, m_oe(rdir, rdat, ropt));
      chk("R2 R7 R9 random pad_out", pad_out, m_out(rdat, ropt, ralt));
      chk("R8 random alt_in", alt_in_o, ropt[1] ? rpad[PI] : 1'b1);
      rd(A_DATA, d);
      chk("R1 R5 random read", d, m_rd(rdir, rdat, rpad));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule